// File: doc/BRIEF.md
# Octant-Folded Twiddle Factor Generator

This block supplies the complex coefficient W = e^(-j2πk/N) to the multiplier of one pipelined FFT stage. It takes an angle index k (0 to N-1, N a power of two of at least 64) and returns the real and imaginary parts as W-bit two's complement numbers with W-1 fraction bits. Only the cosine and sine of angles from 0 up to and including π/4 are kept. That is N/8+1 word pairs instead of N. Every other angle is rebuilt from them in three steps: the index is folded into the first octant, the stored pair is read, and the two parts are swapped and negated as the octant requires.

The three most significant bits of k select the octant and the low log2(N)-3 bits are the offset m within it. Even octants read table entry m. Odd octants read entry N/8-m, which is why the table has one entry more than N/8. Because the table stores only magnitudes of at most 1.0, and +1.0 is held as the largest positive code, negating a part can never overflow.

Both edges use a valid/ready stream with a single output register. An index is taken on a clock edge where in_valid and in_ready are both high, and its result is presented the next cycle. The block raises in_ready whenever the output register is empty or is being drained in the same cycle. While out_valid is high and out_ready is low, the output holds, in_ready stays low and no new index is taken. With out_ready held high, one index can be accepted every cycle.

Top module: `twd_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: For every k, out_re is within 1 LSB of round(2^(W-1)·cos(2πk/N)), with that reference limited to 2^(W-1)-1.
- R3: For every k, out_im is within 1 LSB of round(-2^(W-1)·sin(2πk/N)).
- R4: Index k=0 yields out_re = 2^(W-1)-1 (0x7FFF for W=16) and out_im = 0 exactly.
- R5: Index N/4 yields (0, -(2^(W-1)-1)), index N/2 yields (-(2^(W-1)-1), 0) and index 3N/4 yields (0, 2^(W-1)-1), all exactly.
- R6: For every k from 1 to N-1, the result for N-k has exactly the same out_re and exactly the negated out_im of the result for k.
- R7: After an accepted index (in_valid and in_ready high at a clock edge), out_valid is 1 in the next cycle and the pair belongs to that index.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_re, out_im and out_valid are held unchanged into the next cycle.
- R9: If a result is taken (out_valid and out_ready high) and no index is accepted at the same edge, out_valid is 0 in the next cycle.
- R10: With out_ready held high, indices presented on consecutive cycles are all accepted and their results come out on consecutive cycles in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Angle index is presented |
| in_ready | output | 1 | Block can take an index this cycle |
| in_k | input | log2(N) | Angle index k |
| out_valid | output | 1 | Coefficient pair is presented |
| out_ready | input | 1 | Consumer takes the pair this cycle |
| out_re | output | W | Real part, two's complement |
| out_im | output | W | Imaginary part, two's complement |

## Verification
The bench builds the block with N=256 and W=16. With these values each octant has 32 offsets, so mirrored table reads, both ends of the table (offset 0 and the N/8 entry) and all eight swap/negate patterns are compared against a floating-point reference for every index. Random in_valid and out_ready patterns then exercise stalls, stalls combined with drains, and back-to-back transfers against a cycle-level model of the output register.

// File: rtl/twd_pkg.sv
package twd_pkg;

  typedef logic [2:0] octant_t;

  // Quantise a non-negative magnitude (at most 1.0) to an unsigned code
  // with w-1 fraction bits; 1.0 is limited to the largest positive code.
  function automatic int quant_mag(real x, int w);
    real scaled;
    int  code;
    int  top;
    top    = (1 << (w - 1)) - 1;
    scaled = x * (2.0 ** (w - 1));
    code   = $rtoi(scaled + 0.5);
    if (code > top) code = top;
    if (code < 0)   code = 0;
    return code;
  endfunction

endpackage

// File: rtl/twd_octant_fold.sv
module twd_octant_fold #(
  parameter int N = 64
) (
  input  logic [$clog2(N)-1:0] k,
  output twd_pkg::octant_t     oct,
  output logic [$clog2(N)-3:0] idx
);
  localparam int KW     = $clog2(N);
  localparam int MW     = KW - 3;
  localparam int EIGHTH = N / 8;

  logic [MW-1:0] m;
  logic [MW:0]   m_ext;
  logic [MW:0]   eighth_c;

  assign oct      = k[KW-1 -: 3];
  assign m        = k[MW-1:0];
  assign m_ext    = {1'b0, m};
  assign eighth_c = EIGHTH[MW:0];

  // Odd octants run backwards through the table.
  always_comb begin
    if (oct[0]) idx = eighth_c - m_ext;
    else        idx = m_ext;
  end

endmodule

// File: rtl/twd_octant_rom.sv
module twd_octant_rom #(
  parameter int N = 64,
  parameter int W = 16
) (
  input  logic [$clog2(N)-3:0] idx,
  output logic [W-1:0]         cos_mag,
  output logic [W-1:0]         sin_mag
);
  localparam int  IW    = $clog2(N) - 2;
  localparam int  DEPTH = N / 8 + 1;
  localparam real PI    = 3.14159265358979323846;

  logic [W-1:0] cos_tab [DEPTH];
  logic [W-1:0] sin_tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam real ANG = 2.0 * PI * i / N;
    localparam int  CQ  = twd_pkg::quant_mag($cos(ANG), W);
    localparam int  SQ  = twd_pkg::quant_mag($sin(ANG), W);
    assign cos_tab[i] = CQ[W-1:0];
    assign sin_tab[i] = SQ[W-1:0];
  end

  always_comb begin
    cos_mag = '0;
    sin_mag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IW'(i)) begin
        cos_mag = cos_tab[i];
        sin_mag = sin_tab[i];
      end
    end
  end

endmodule

// File: rtl/twd_octant_map.sv
module twd_octant_map #(
  parameter int W = 16
) (
  input  twd_pkg::octant_t   oct,
  input  logic [W-1:0]       cos_mag,
  input  logic [W-1:0]       sin_mag,
  output logic signed [W-1:0] re,
  output logic signed [W-1:0] im
);
  logic signed [W-1:0] c_pos, s_pos, c_neg, s_neg;

  assign c_pos = cos_mag;
  assign s_pos = sin_mag;
  assign c_neg = -c_pos;
  assign s_neg = -s_pos;

  always_comb begin
    unique case (oct)
      3'd0: begin re = c_pos; im = s_neg; end
      3'd1: begin re = s_pos; im = c_neg; end
      3'd2: begin re = s_neg; im = c_neg; end
      3'd3: begin re = c_neg; im = s_neg; end
      3'd4: begin re = c_neg; im = s_pos; end
      3'd5: begin re = s_neg; im = c_pos; end
      3'd6: begin re = s_pos; im = c_pos; end
      default: begin re = c_pos; im = s_pos; end
    endcase
  end

endmodule

// File: rtl/twd_gen.sv
module twd_gen #(
  parameter int N = 64,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [$clog2(N)-1:0] in_k,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [W-1:0]  out_re,
  output logic signed [W-1:0]  out_im
);
  localparam int IW = $clog2(N) - 2;

  twd_pkg::octant_t    oct;
  logic [IW-1:0]       idx;
  logic [W-1:0]        cmag, smag;
  logic signed [W-1:0] re_c, im_c;
  logic                take;

  twd_octant_fold #(.N(N)) u_fold (
    .k   (in_k),
    .oct (oct),
    .idx (idx)
  );

  twd_octant_rom #(.N(N), .W(W)) u_rom (
    .idx     (idx),
    .cos_mag (cmag),
    .sin_mag (smag)
  );

  twd_octant_map #(.W(W)) u_map (
    .oct     (oct),
    .cos_mag (cmag),
    .sin_mag (smag),
    .re      (re_c),
    .im      (im_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_re    <= re_c;
        out_im    <= im_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/twd_gen_chk.sv
module twd_gen_chk #(
  parameter int N = 64,
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [$clog2(N)-1:0] in_k,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [W-1:0]  out_re,
  input logic signed [W-1:0]  out_im
);
  localparam int KW = $clog2(N);
  localparam logic signed [W-1:0] PMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NMAX = -PMAX;
  localparam logic [KW-1:0] K_HALF = KW'(N / 2);

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && in_ready); // R1

  AST_ZERO_ANGLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_k == '0 |=> out_re == PMAX && out_im == '0); // R4

  AST_HALF_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_k == K_HALF |=> out_re == NMAX && out_im == '0); // R5

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)); // R8

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9

endmodule

bind twd_gen twd_gen_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_k      (in_k),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/twd_gen_tb_top.sv
module twd_gen_tb_top;
  localparam int  N  = 256;
  localparam int  W  = 16;
  localparam int  KW = $clog2(N);
  localparam int  PM = (1 << (W - 1)) - 1;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [KW-1:0] in_k = '0;
  logic in_ready, out_valid;
  logic signed [W-1:0] out_re, out_im;

  always #4 clk = ~clk;

  twd_gen #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_k(in_k), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;

  int  exp_q[$];
  bit  m_ov = 0;
  bit  m_stall = 0;
  int  held_re, held_im;
  int  got_re [N];
  int  got_im [N];
  bit  got_ok [N];

  function automatic int rnd(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int ref_re(int k);
    int r = rnd($cos(2.0 * PI * k / N) * (2.0 ** (W - 1)));
    if (r > PM) r = PM;
    return r;
  endfunction

  function automatic int ref_im(int k);
    int r = rnd(-$sin(2.0 * PI * k / N) * (2.0 ** (W - 1)));
    if (r > PM) r = PM;
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // One cycle: check outputs against the model, drive, update the model.
  task automatic step(bit iv, int k, bit ordy);
    int d;
    @(negedge clk);
    chk(out_valid == m_ov, "R7/R9 out_valid", int'(out_valid), int'(m_ov));
    if (m_stall) begin
      chk(out_re == held_re, "R8 held re", out_re, held_re);
      chk(out_im == held_im, "R8 held im", out_im, held_im);
    end
    in_valid  = iv;
    in_k      = KW'(k);
    out_ready = ordy;
    #1;
    chk(in_ready == (!m_ov || ordy), "R8 in_ready", int'(in_ready), int'(!m_ov || ordy));
    if (m_ov && ordy && exp_q.size() > 0) begin
      int ek;
      ek = exp_q.pop_front();
      d = int'(out_re) - ref_re(ek);
      chk(d <= 1 && d >= -1, "R2 re", out_re, ref_re(ek));
      d = int'(out_im) - ref_im(ek);
      chk(d <= 1 && d >= -1, "R3 im", out_im, ref_im(ek));
      got_re[ek] = out_re;
      got_im[ek] = out_im;
      got_ok[ek] = 1'b1;
    end
    m_stall = m_ov && !ordy;
    held_re = out_re;
    held_im = out_im;
    if (iv && in_ready) begin
      exp_q.push_back(k);
      m_ov = 1'b1;
    end else if (ordy) begin
      m_ov = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    // R10: full sweep, back-to-back, consumer always ready
    for (int k = 0; k < N; k++) step(1'b1, k, 1'b1);
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    for (int k = 0; k < N; k++)
      chk(got_ok[k], "R10 result delivered", int'(got_ok[k]), 1);
    chk(got_re[0] == PM && got_im[0] == 0, "R4 k=0 re", got_re[0], PM);
    chk(got_im[0] == 0, "R4 k=0 im", got_im[0], 0);
    chk(got_re[N/4] == 0 && got_im[N/4] == -PM, "R5 quarter im", got_im[N/4], -PM);
    chk(got_re[N/2] == -PM && got_im[N/2] == 0, "R5 half re", got_re[N/2], -PM);
    chk(got_re[3*N/4] == 0 && got_im[3*N/4] == PM, "R5 three-quarter im", got_im[3*N/4], PM);
    for (int k = 1; k < N; k++) begin
      chk(got_re[N-k] == got_re[k], "R6 mirror re", got_re[N-k], got_re[k]);
      chk(got_im[N-k] == -got_im[k], "R6 mirror im", got_im[N-k], -got_im[k]);
    end
    // R8/R9: random handshakes with stalls
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)),
           1'($urandom_range(0, 3) != 0));
    // long stall then drain
    step(1'b1, N / 8, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 7, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
    finish_run();
  end

endmodule